// File: doc/BRIEF.md
# Dual Comparator Control and Port Pin Multiplexer

This block holds the byte-wide control register for two on-chip comparators and steers seven port pins between general-purpose I/O, comparator inputs, comparator outputs and a PWM output. It never sees the analog comparison itself. Each comparator's result arrives as one digital bit. The block forwards that bit to a pin, makes it readable on the register bus, and can feed it into a pin-change interrupt path.

Software writes the register over a simple byte bus and reads it back combinationally. While a comparator is disabled, all of its pins behave as ordinary port pins, fed from the port register model through `gpio_out` and `gpio_oe`. Enabling a comparator takes its input pins away from output drive. Its output pin is driven only when its output-enable bit is also set.

Pin 6 is shared by three sources. Comparator 2 has the highest priority, the PWM comes next, and general-purpose I/O comes last. Each comparator has an interrupt state machine with two named states. `INT_IDLE` moves to `INT_PEND` on a qualifying edge. `INT_PEND` returns to `INT_IDLE` on a clear pulse, unless a new edge arrives in the same cycle.

Top module: `cmp_pin_ctrl`

## Requirements
- R1: After reset every writable control bit is 0. The register reads 0x00, both interrupt flags are clear, and all seven pins follow `gpio_out`/`gpio_oe`.
- R2: The control register answers at bus address 0xD3 and has this layout: bit 7 comparator 2 input select, bit 6 comparator 2 output enable, bit 5 comparator 2 result, bit 4 comparator 2 enable, bit 3 comparator 1 output enable, bit 2 comparator 1 result, bit 1 comparator 1 enable. A read at any other address returns 0x00, and a write to any other address leaves the register unchanged.
- R3: Bits 5, 2 and 0 ignore writes. Bit 0 always reads 0.
- R4: Read bit 2 (comparator 1) and read bit 5 (comparator 2) return the comparator result, delayed by two clock edges through a synchronizer, while that comparator's enable bit is 1. They read 0 while it is 0.
- R5: With comparator 1 enabled, pins 0 and 1 have their output enable forced to 0. Pin 2 drives the comparator 1 result with its output enable at 1 only when both bit 1 and bit 3 are 1.
- R6: With comparator 2 enabled, pin 4 has its output enable forced to 0, as does the negative-input pin: pin 5 when bit 7 is 0, pin 3 when bit 7 is 1. The unselected pin stays general-purpose I/O. `cmp2_neg_sel` equals bit 7.
- R7: Pin 6 drives the comparator 2 result when bits 4 and 6 are both 1. Otherwise it drives `pwm_out` when `pwm_en` is 1. Otherwise it follows general-purpose I/O.
- R8: While a comparator's enable bit is 0, its output-enable and select bits have no effect, and all of its pins follow general-purpose I/O (or the PWM on pin 6).
- R9: When comparator n (index 0 = comparator 1, 1 = comparator 2) is enabled and `irq_route[n]` and `irq_en[n]` are both 1, `irq_pend[n]` sets three clock edges after the result input changes. It sets on a rise when `irq_rise[n]` is 1 and on a fall when `irq_rise[n]` is 0. An edge of the other polarity, or any edge while a gate is off, has no effect.
- R10: A set `irq_pend[n]` stays set until a one-cycle pulse on `irq_clr[n]` clears it. A qualifying edge in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| cmp_res | input | 2 | Comparator results, bit 0 = comparator 1 |
| gpio_out | input | 7 | Port register output values |
| gpio_oe | input | 7 | Port register output enables |
| pwm_out | input | 1 | PWM waveform for pin 6 |
| pwm_en | input | 1 | PWM owns pin 6 when not pre-empted |
| irq_route | input | 2 | Route comparator result to the pin interrupt |
| irq_en | input | 2 | Per-comparator interrupt enable |
| irq_rise | input | 2 | Edge select: 1 rising, 0 falling |
| irq_clr | input | 2 | Pending flag clear pulses |
| pin_out | output | 7 | Pin output values |
| pin_oe | output | 7 | Pin output enables |
| cmp2_neg_sel | output | 1 | Comparator 2 negative input select, 1 = pin 3 |
| irq_pend | output | 2 | Interrupt pending flags, bit 0 = pin 0, bit 1 = pin 4 |

## Verification
The bench writes all 256 byte values to the register. For each one it tries every pair of comparator results, every PWM request and two general-purpose patterns, so every input-select, pin-mux and priority combination is covered. That sweep catches a design that drives an output pin with the output-enable bit set but the comparator disabled, a design that floats the wrong negative-input pin, and a design that lets the PWM override the comparator on pin 6. It also catches a design that lets a write reach the read-only bits, or reports a stale result on a disabled comparator. The interrupt tests check the exact edge on which a flag sets, that the edge of the other polarity is ignored, that disabling the comparator or the interrupt blocks the flag, and that the flag holds until cleared.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    // control register bit positions (fixed by the software view)
    localparam int B_SEL2 = 7;
    localparam int B_OE2  = 6;
    localparam int B_RD2  = 5;
    localparam int B_EN2  = 4;
    localparam int B_OE1  = 3;
    localparam int B_RD1  = 2;
    localparam int B_EN1  = 1;
    localparam int B_RSV  = 0;

    // port pin roles
    localparam int P_C1_POS = 0;
    localparam int P_C1_NEG = 1;
    localparam int P_C1_OUT = 2;
    localparam int P_C2_NGB = 3;
    localparam int P_C2_POS = 4;
    localparam int P_C2_NGA = 5;
    localparam int P_C2_OUT = 6;

    typedef struct packed {
        logic sel2;
        logic oe2;
        logic en2;
        logic oe1;
        logic en1;
    } cmp_ctrl_t;

    typedef enum logic {
        INT_IDLE = 1'b0,
        INT_PEND = 1'b1
    } irq_state_t;
endpackage

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
    import cmp_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic [1:0]        res_sync,
    output logic [7:0]        bus_rdata,
    output cmp_ctrl_t         ctrl
);
    cmp_ctrl_t ctrl_q;
    logic      hit;
    logic [7:0] view;

    assign hit = (bus_addr == CTRL_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr && hit) begin
            ctrl_q.sel2 <= bus_wdata[B_SEL2];
            ctrl_q.oe2  <= bus_wdata[B_OE2];
            ctrl_q.en2  <= bus_wdata[B_EN2];
            ctrl_q.oe1  <= bus_wdata[B_OE1];
            ctrl_q.en1  <= bus_wdata[B_EN1];
        end
    end

    always_comb begin
        view         = '0;
        view[B_SEL2] = ctrl_q.sel2;
        view[B_OE2]  = ctrl_q.oe2;
        view[B_RD2]  = ctrl_q.en2 & res_sync[1];
        view[B_EN2]  = ctrl_q.en2;
        view[B_OE1]  = ctrl_q.oe1;
        view[B_RD1]  = ctrl_q.en1 & res_sync[0];
        view[B_EN1]  = ctrl_q.en1;
        view[B_RSV]  = 1'b0;
        bus_rdata    = hit ? view : 8'h00;
    end

    assign ctrl = ctrl_q;

    // R2
    foreign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit) |=> $stable(ctrl_q));
    // R3
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[B_RSV]);
    // R4
    rd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ctrl_q.en1) |-> !bus_rdata[B_RD1]);
endmodule

// File: rtl/cmp_edge_irq.sv
module cmp_edge_irq
    import cmp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic res_in,
    input  logic cmp_en,
    input  logic route,
    input  logic irq_en,
    input  logic rise_sel,
    input  logic clr,
    output logic res_sync,
    output logic pend
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   edge_hit;
    irq_state_t             state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], res_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign res_sync = sync_q[SYNC_STAGES-1];
    assign edge_hit = cmp_en && route && irq_en &&
                      (rise_sel ? (res_sync && !prev_q) : (!res_sync && prev_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= INT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INT_IDLE: if (edge_hit)         state_d = INT_PEND;
            INT_PEND: if (clr && !edge_hit) state_d = INT_IDLE;
            default:                        state_d = INT_IDLE;
        endcase
    end

    assign pend = (state_q == INT_PEND);

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);
    // R9
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && (!cmp_en || !route || !irq_en)) |=> !pend);
endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux
    import cmp_pkg::*;
#(
    parameter int NPINS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmp_ctrl_t        ctrl,
    input  logic [1:0]       cmp_res,
    input  logic [NPINS-1:0] gpio_out,
    input  logic [NPINS-1:0] gpio_oe,
    input  logic             pwm_out,
    input  logic             pwm_en,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);
    always_comb begin
        pin_out = gpio_out;
        pin_oe  = gpio_oe;
        if (pwm_en) begin
            pin_oe[P_C2_OUT]  = 1'b1;
            pin_out[P_C2_OUT] = pwm_out;
        end
        if (ctrl.en1) begin
            pin_oe[P_C1_POS] = 1'b0;
            pin_oe[P_C1_NEG] = 1'b0;
            if (ctrl.oe1) begin
                pin_oe[P_C1_OUT]  = 1'b1;
                pin_out[P_C1_OUT] = cmp_res[0];
            end
        end
        if (ctrl.en2) begin
            pin_oe[P_C2_POS] = 1'b0;
            if (ctrl.sel2) pin_oe[P_C2_NGB] = 1'b0;
            else           pin_oe[P_C2_NGA] = 1'b0;
            if (ctrl.oe2) begin
                pin_oe[P_C2_OUT]  = 1'b1;
                pin_out[P_C2_OUT] = cmp_res[1];
            end
        end
    end

    // R7
    c2_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en2 && ctrl.oe2) |-> (pin_oe[P_C2_OUT] && pin_out[P_C2_OUT] == cmp_res[1]));
    // R5
    c1_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.en1 |-> (pin_oe[P_C1_NEG:P_C1_POS] == 2'b00));
    // R8
    c1_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en1 |-> (pin_oe[P_C1_OUT:P_C1_POS] == gpio_oe[P_C1_OUT:P_C1_POS]));
endmodule

// File: rtl/cmp_pin_ctrl.sv
module cmp_pin_ctrl
    import cmp_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter logic [7:0]  CTRL_ADDR   = 8'hD3,
    parameter int          SYNC_STAGES = 2,
    parameter int          NPINS       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [1:0]       cmp_res,
    input  logic [6:0]       gpio_out,
    input  logic [6:0]       gpio_oe,
    input  logic             pwm_out,
    input  logic             pwm_en,
    input  logic [1:0]       irq_route,
    input  logic [1:0]       irq_en,
    input  logic [1:0]       irq_rise,
    input  logic [1:0]       irq_clr,
    output logic [6:0]       pin_out,
    output logic [6:0]       pin_oe,
    output logic             cmp2_neg_sel,
    output logic [1:0]       irq_pend
);
    localparam int NCMP = 2;

    cmp_ctrl_t       ctrl;
    logic [NCMP-1:0] res_sync;
    logic [NCMP-1:0] cmp_on;

    assign cmp_on = {ctrl.en2, ctrl.en1};

    cmp_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .res_sync(res_sync), .bus_rdata(bus_rdata), .ctrl(ctrl)
    );

    for (genvar i = 0; i < NCMP; i++) begin : g_irq
        cmp_edge_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
            .clk(clk), .rst_n(rst_n),
            .res_in(cmp_res[i]), .cmp_en(cmp_on[i]),
            .route(irq_route[i]), .irq_en(irq_en[i]),
            .rise_sel(irq_rise[i]), .clr(irq_clr[i]),
            .res_sync(res_sync[i]), .pend(irq_pend[i])
        );
    end

    cmp_pin_mux #(.NPINS(NPINS)) u_mux (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cmp_res(cmp_res),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .pwm_out(pwm_out), .pwm_en(pwm_en),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    assign cmp2_neg_sel = ctrl.sel2;
endmodule

// File: tb/cmp_pin_ctrl_tb.sv
module cmp_pin_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
    logic       bus_wr = 1'b0;
    logic [1:0] cmp_res = 2'b00;
    logic [6:0] gpio_out = 7'h00, gpio_oe = 7'h00, pin_out, pin_oe;
    logic       pwm_out = 1'b0, pwm_en = 1'b0, cmp2_neg_sel;
    logic [1:0] irq_route = 2'b00, irq_en = 2'b00, irq_rise = 2'b00, irq_clr = 2'b00, irq_pend;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    cmp_pin_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_res(cmp_res),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pwm_out(pwm_out), .pwm_en(pwm_en),
        .irq_route(irq_route), .irq_en(irq_en), .irq_rise(irq_rise), .irq_clr(irq_clr),
        .pin_out(pin_out), .pin_oe(pin_oe), .cmp2_neg_sel(cmp2_neg_sel), .irq_pend(irq_pend)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'hD3;
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        @(negedge clk);
        irq_clr = m;
        @(negedge clk);
        irq_clr = 2'b00;
    endtask

    // expected pin state, derived from R5..R8
    task automatic exp_pins(input logic [7:0] w, output logic [6:0] eo, output logic [6:0] ee);
        logic e1, e2;
        e1 = w[1]; e2 = w[4];
        eo = gpio_out; ee = gpio_oe;
        for (int p = 0; p < 7; p++) begin
            if (e1 && (p == 0 || p == 1)) ee[p] = 1'b0;
            if (e2 && (p == 4 || (p == 5 && !w[7]) || (p == 3 && w[7]))) ee[p] = 1'b0;
        end
        if (e1 && w[3]) begin ee[2] = 1'b1; eo[2] = cmp_res[0]; end
        if (e2 && w[6]) begin ee[6] = 1'b1; eo[6] = cmp_res[1]; end
        else if (pwm_en) begin ee[6] = 1'b1; eo[6] = pwm_out; end
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [6:0] eo, ee;
        logic [7:0] erd;
        gpio_out = 7'h55; gpio_oe = 7'h7F; bus_addr = 8'hD3;
        edges(2);
        // R1: reset state
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 pin_oe", {1'b0, pin_oe}, {1'b0, gpio_oe});
        chk("R1 pin_out", {1'b0, pin_out}, {1'b0, gpio_out});
        chk("R1 pend", {6'd0, irq_pend}, 8'h00);
        rst_n = 1'b1;
        edges(1);
        chk("R1 rdata after release", bus_rdata, 8'h00);

        // R2: other addresses
        wr(8'hD2, 8'hFF);
        chk("R2 foreign write", bus_rdata, 8'h00);
        wr(8'hD3, 8'h12);
        bus_addr = 8'hD4;
        #1 chk("R2 foreign read", bus_rdata, 8'h00);
        bus_addr = 8'hD3;

        // R2..R8 full sweep
        for (int w = 0; w < 256; w++) begin
            wr(8'hD3, w[7:0]);
            for (int r = 0; r < 4; r++) begin
                cmp_res = r[1:0];
                edges(2);
                erd = {w[7], w[6], w[4] & cmp_res[1], w[4], w[3], w[1] & cmp_res[0], w[1], 1'b0};
                chk("R2 R3 R4 readback", bus_rdata, erd);
                chk("R6 neg sel", {7'd0, cmp2_neg_sel}, {7'd0, w[7]});
                for (int v = 0; v < 8; v++) begin
                    pwm_en = v[0]; pwm_out = v[1];
                    gpio_out = v[2] ? 7'h2A : 7'h55;
                    gpio_oe  = v[2] ? 7'h00 : 7'h7F;
                    #1;
                    exp_pins(w[7:0], eo, ee);
                    chk("R5 R6 R7 R8 pin_oe", {1'b0, pin_oe}, {1'b0, ee});
                    chk("R5 R6 R7 R8 pin_out", {1'b0, pin_out}, {1'b0, eo});
                end
            end
        end

        // R9 / R10 interrupts
        pwm_en = 1'b0;
        cmp_res = 2'b00;
        wr(8'hD3, 8'h12);
        irq_route = 2'b11; irq_en = 2'b11; irq_rise = 2'b01;
        edges(4);
        pulse_clr(2'b11);
        chk("R9 idle", {6'd0, irq_pend}, 8'h00);
        @(negedge clk); cmp_res = 2'b11;
        edges(2);
        chk("R9 not yet", {6'd0, irq_pend}, 8'h00);
        edges(1);
        chk("R9 rising sets pin0 only", {6'd0, irq_pend}, 8'h01);
        @(negedge clk); cmp_res = 2'b00;
        edges(3);
        chk("R9 R10 falling sets pin4, pin0 held", {6'd0, irq_pend}, 8'h03);
        edges(5);
        chk("R10 held", {6'd0, irq_pend}, 8'h03);
        pulse_clr(2'b01);
        chk("R10 clear one", {6'd0, irq_pend}, 8'h02);
        pulse_clr(2'b10);
        chk("R10 clear other", {6'd0, irq_pend}, 8'h00);
        irq_en = 2'b00;
        @(negedge clk); cmp_res = 2'b11;
        edges(4);
        @(negedge clk); cmp_res = 2'b00;
        edges(4);
        chk("R9 irq_en off", {6'd0, irq_pend}, 8'h00);
        irq_en = 2'b11;
        wr(8'hD3, 8'h00);
        @(negedge clk); cmp_res = 2'b11;
        edges(4);
        @(negedge clk); cmp_res = 2'b00;
        edges(4);
        chk("R9 R8 comparator off", {6'd0, irq_pend}, 8'h00);
        wr(8'hD3, 8'h12);
        irq_route = 2'b00;
        @(negedge clk); cmp_res = 2'b11;
        edges(4);
        chk("R9 route off", {6'd0, irq_pend}, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule